// File: doc/BRIEF.md
# Write-Side Queue and Flag-Device Selector

This block sits on the write side of a buffer that holds several independent queues. It watches a small address bus together with two strobes. A queue-change strobe picks which queue later writes land in. A flag strobe picks which device drives a shared almost-full flag bus. Every decision is taken on the rising edge of the free-running write clock, and every output is a register.

A queue change is a cycle of its own. It is refused until configuration has finished, which a low done input signals. It is also refused when the flag strobe is high in the same cycle, or when the address names a queue that does not exist. Each refusal leaves all selection state unchanged and raises a one-cycle error pulse. While the active-low write enable is held, each edge produces one write strobe, tagged with the queue that was selected before that edge. Writes stay suppressed until a queue has been accepted after reset.

Top module: `wrq_selector`

## Requirements
- R1: After a synchronous reset, `sel_queue` and `flag_dev` are 0, and `wr_stb` and `rule_err` are 0.
- R2: On an edge where `addr_en`=1, `flag_stb`=0, `cfg_done_n`=0 and `wr_addr` < NUM_QUEUES (5), `sel_queue` holds the value of `wr_addr` from the next cycle onward.
- R3: On an edge where `flag_stb`=1 and `addr_en`=0, `flag_dev` takes `wr_addr` (its low DW bits) from the next cycle onward, whether or not configuration is done.
- R4: On an edge where `addr_en` and `flag_stb` are both 1, neither `sel_queue` nor `flag_dev` changes, and `rule_err` is 1 for the following cycle.
- R5: On an edge where `addr_en`=1 and `cfg_done_n`=1, `sel_queue` does not change and `rule_err` is 1 for the following cycle.
- R6: On an edge where `addr_en`=1 and `wr_addr` >= NUM_QUEUES, `sel_queue` does not change and `rule_err` is 1 for the following cycle. `sel_queue` is always below NUM_QUEUES.
- R7: On an edge where `wr_en_n`=0 and a queue has been accepted, `wr_stb` is 1 in the next cycle and `wr_stb_queue` equals the `sel_queue` held before that edge. A write made in a queue-change cycle therefore goes to the old queue.
- R8: Until a queue selection has been accepted after reset, `wr_stb` stays 0 whatever `wr_en_n` does.
- R9: On an edge where `wr_en_n`=1, `wr_stb` is 0 in the next cycle. On an edge with no rule violation, `rule_err` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running write clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_addr | input | AW | Address bus: a queue number or a flag-device number |
| addr_en | input | 1 | Queue-change strobe |
| flag_stb | input | 1 | Flag-device select strobe |
| wr_en_n | input | 1 | Active-low write enable |
| cfg_done_n | input | 1 | Low once configuration has completed |
| sel_queue | output | QW | Selected write queue |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_stb_queue | output | QW | Queue that the current write strobe targets |
| flag_dev | output | DW | Device selected to drive the flag bus |
| rule_err | output | 1 | One-cycle pulse after a refused or illegal cycle |

## Verification
The assertions assume that every input is known and stable around each rising edge once reset has been released, and that reset is held for at least two edges. The bench drives all inputs on the falling edge and samples on the next falling edge, so inputs never change near the sampling edge. The sweep covers every combination of the two strobes, the enable, the done input and all eight address values. It runs first with configuration pending and then with configuration done, so every legal and illegal case reaches the design.

// File: rtl/wrq_pkg.sv
package wrq_pkg;

  typedef struct packed {
    logic take_queue;
    logic take_dev;
    logic violation;
  } wrq_cmd_t;

  function automatic int unsigned bits_for(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/wrq_rule_check.sv
module wrq_rule_check
  import wrq_pkg::*;
#(
  parameter int unsigned NUM_QUEUES = 5,
  parameter int unsigned AW         = 3
) (
  input  logic          addr_en,
  input  logic          flag_stb,
  input  logic          cfg_done_n,
  input  logic [AW-1:0] wr_addr,
  output wrq_cmd_t      cmd
);

  logic in_range;

  generate
    if (NUM_QUEUES == (1 << AW)) begin : g_full
      assign in_range = 1'b1;
    end else begin : g_cmp
      assign in_range = ({{(32-AW){1'b0}}, wr_addr} < 32'(NUM_QUEUES));
    end
  endgenerate

  always_comb begin
    cmd.take_queue = addr_en && !flag_stb && !cfg_done_n && in_range;
    cmd.take_dev   = flag_stb && !addr_en;
    cmd.violation  = addr_en && (flag_stb || cfg_done_n || !in_range);
  end

endmodule

// File: rtl/wrq_sel_reg.sv
module wrq_sel_reg #(
  parameter int unsigned QW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [QW-1:0] next_queue,
  output logic [QW-1:0] sel_queue,
  output logic          q_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_queue <= '0;
      q_valid   <= 1'b0;
    end else if (take) begin
      sel_queue <= next_queue;
      q_valid   <= 1'b1;
    end
  end

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
    q_valid |=> q_valid); // R8

endmodule

// File: rtl/wrq_flag_reg.sv
module wrq_flag_reg #(
  parameter int unsigned DW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [DW-1:0] next_dev,
  output logic [DW-1:0] flag_dev
);

  always_ff @(posedge clk) begin
    if (rst) flag_dev <= '0;
    else if (take) flag_dev <= next_dev;
  end

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(flag_dev)); // R4

endmodule

// File: rtl/wrq_wr_tag.sv
module wrq_wr_tag #(
  parameter int unsigned QW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en_n,
  input  logic          q_valid,
  input  logic [QW-1:0] sel_queue,
  output logic          wr_stb,
  output logic [QW-1:0] wr_stb_queue
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_stb       <= 1'b0;
      wr_stb_queue <= '0;
    end else begin
      wr_stb <= !wr_en_n && q_valid;
      if (!wr_en_n && q_valid) wr_stb_queue <= sel_queue;
    end
  end

  AST_NO_WRITE_UNSELECTED: assert property (@(posedge clk) disable iff (rst)
    !q_valid |=> !wr_stb); // R8

  AST_WR_IDLE: assert property (@(posedge clk) disable iff (rst)
    wr_en_n |=> !wr_stb); // R9

endmodule

// File: rtl/wrq_selector.sv
module wrq_selector
  import wrq_pkg::*;
#(
  parameter int unsigned NUM_QUEUES = 5,
  parameter int unsigned NUM_DEVS   = 8,
  localparam int unsigned QW = bits_for(NUM_QUEUES),
  localparam int unsigned DW = bits_for(NUM_DEVS),
  localparam int unsigned AW = (QW > DW) ? QW : DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] wr_addr,
  input  logic          addr_en,
  input  logic          flag_stb,
  input  logic          wr_en_n,
  input  logic          cfg_done_n,
  output logic [QW-1:0] sel_queue,
  output logic          wr_stb,
  output logic [QW-1:0] wr_stb_queue,
  output logic [DW-1:0] flag_dev,
  output logic          rule_err
);

  wrq_cmd_t cmd;
  logic     q_valid;

  wrq_rule_check #(.NUM_QUEUES(NUM_QUEUES), .AW(AW)) rule_i (
    .addr_en   (addr_en),
    .flag_stb  (flag_stb),
    .cfg_done_n(cfg_done_n),
    .wr_addr   (wr_addr),
    .cmd       (cmd)
  );

  wrq_sel_reg #(.QW(QW)) sel_i (
    .clk       (clk),
    .rst       (rst),
    .take      (cmd.take_queue),
    .next_queue(wr_addr[QW-1:0]),
    .sel_queue (sel_queue),
    .q_valid   (q_valid)
  );

  wrq_flag_reg #(.DW(DW)) flag_i (
    .clk     (clk),
    .rst     (rst),
    .take    (cmd.take_dev),
    .next_dev(wr_addr[DW-1:0]),
    .flag_dev(flag_dev)
  );

  wrq_wr_tag #(.QW(QW)) wr_i (
    .clk         (clk),
    .rst         (rst),
    .wr_en_n     (wr_en_n),
    .q_valid     (q_valid),
    .sel_queue   (sel_queue),
    .wr_stb      (wr_stb),
    .wr_stb_queue(wr_stb_queue)
  );

  always_ff @(posedge clk) begin
    if (rst) rule_err <= 1'b0;
    else     rule_err <= cmd.violation;
  end

  AST_ERR_ON_CLASH: assert property (@(posedge clk) disable iff (rst)
    (addr_en && flag_stb) |=> rule_err); // R4

  AST_CLASH_HOLDS_QUEUE: assert property (@(posedge clk) disable iff (rst)
    (addr_en && flag_stb) |=> $stable(sel_queue)); // R4

  AST_LOCKED_BEFORE_CFG: assert property (@(posedge clk) disable iff (rst)
    (addr_en && cfg_done_n) |=> ($stable(sel_queue) && rule_err)); // R5

  AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    ({{(32-QW){1'b0}}, sel_queue} < 32'(NUM_QUEUES))); // R6

  AST_NO_SPURIOUS_ERR: assert property (@(posedge clk) disable iff (rst)
    !addr_en |=> !rule_err); // R9

endmodule

// File: tb/wrq_selector_tb_top.sv
`timescale 1ns/1ps
module wrq_selector_tb_top;

  localparam int NQ = 5;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] wr_addr;
  logic       addr_en, flag_stb, wr_en_n, cfg_done_n;
  logic [2:0] sel_queue, wr_stb_queue, flag_dev;
  logic       wr_stb, rule_err;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  wrq_selector #(.NUM_QUEUES(NQ), .NUM_DEVS(8)) dut_i (
    .clk(clk), .rst(rst), .wr_addr(wr_addr), .addr_en(addr_en),
    .flag_stb(flag_stb), .wr_en_n(wr_en_n), .cfg_done_n(cfg_done_n),
    .sel_queue(sel_queue), .wr_stb(wr_stb), .wr_stb_queue(wr_stb_queue),
    .flag_dev(flag_dev), .rule_err(rule_err)
  );

  // bench-side expectation state
  int  m_sel, m_dev;
  bit  m_valid;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; addr_en = 0; flag_stb = 0; wr_en_n = 1; cfg_done_n = 1; wr_addr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    m_sel = 0; m_dev = 0; m_valid = 0;
    check("R1", "sel_queue", int'(sel_queue), 0);
    check("R1", "flag_dev",  int'(flag_dev), 0);
    check("R1", "wr_stb",    int'(wr_stb), 0);
    check("R1", "rule_err",  int'(rule_err), 0);
  endtask

  // inputs are driven right after a falling edge; results checked on the next one
  task automatic step(input bit ae, input bit fs, input int addr, input bit wen_n, input bit cfgn);
    string rq_sel, rq_wr;
    bit    exp_err, exp_wr;
    int    exp_wq;
    addr_en = ae; flag_stb = fs; wr_addr = 3'(addr); wr_en_n = wen_n; cfg_done_n = cfgn;

    exp_err = ae && (fs || cfgn || addr >= NQ);
    exp_wr  = !wen_n && m_valid;
    exp_wq  = m_sel;
    if (ae && fs)          rq_sel = "R4";
    else if (ae && cfgn)   rq_sel = "R5";
    else if (ae && addr >= NQ) rq_sel = "R6";
    else if (ae)           rq_sel = "R2";
    else if (fs)           rq_sel = "R3";
    else                   rq_sel = "R9";
    if (wen_n)        rq_wr = "R9";
    else if (m_valid) rq_wr = "R7";
    else              rq_wr = "R8";

    if (ae && !fs && !cfgn && addr < NQ) begin m_sel = addr; m_valid = 1; end
    if (fs && !ae) m_dev = addr;

    @(negedge clk);
    check(rq_sel, "sel_queue", int'(sel_queue), m_sel);
    check(rq_sel, "flag_dev",  int'(flag_dev), m_dev);
    check(rq_sel, "rule_err",  int'(rule_err), int'(exp_err));
    check(rq_wr,  "wr_stb",    int'(wr_stb), int'(exp_wr));
    if (exp_wr) check(rq_wr, "wr_stb_queue", int'(wr_stb_queue), exp_wq);
  endtask

  initial begin
    rst = 1; addr_en = 0; flag_stb = 0; wr_en_n = 1; cfg_done_n = 1; wr_addr = 0;
    do_reset();
    // pass 1: configuration pending, so every queue change is refused (R5, R8)
    // pass 2: configuration done
    for (int c = 1; c >= 0; c--)
      for (int ae = 0; ae < 2; ae++)
        for (int fs = 0; fs < 2; fs++)
          for (int a = 0; a < 8; a++)
            for (int w = 0; w < 2; w++)
              step(bit'(ae), bit'(fs), (a * 3 + c) % 8, bit'(w), bit'(c));
    // write in the same cycle as a queue change goes to the old queue (R7)
    step(1, 0, 1, 0, 0);
    step(1, 0, 4, 0, 0);
    step(0, 0, 0, 0, 0);
    // second reset: selection lost, writes suppressed again (R1, R8)
    do_reset();
    step(0, 0, 2, 0, 0);
    step(0, 1, 6, 0, 0);
    step(1, 0, 3, 0, 0);
    step(0, 0, 0, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

endmodule